// File: doc/BRIEF.md
# Time-of-Day Counter with Slew Corrections

This block keeps a free-running time of day for precision time stamping. The time is held as a 48-bit seconds count, a nanoseconds count that wraps at one billion, and a 16-bit binary fraction of a nanosecond. On each clock edge the time grows by a programmable step. The step is a 32-bit value with 16 integer nanosecond bits above 16 fraction bits. When nanoseconds reach one billion, the counter moves a second into the seconds count.

Software can correct the clock in three ways without stepping the time backwards. A counted burst swaps the normal step for an alternate step to slew phase. A periodic trim adds a small fractional amount every N edges to adjust frequency. A direct load writes a new time. A single-cycle read/write strobe interface gives access to all settings. Reading the nanoseconds word freezes a copy of the seconds, so a read sequence of nanoseconds, seconds-low and seconds-high returns one consistent time. Writing seconds-high, then seconds-low, then nanoseconds loads a new time, and the nanoseconds write commits it.

The alternate-step burst is controlled by a two-state machine. In state BURST_IDLE the normal step is used. A nonzero burst-count write takes it to BURST_RUN, where the alternate step is used. It returns to BURST_IDLE when its remaining count is used up, or at once when zero is written to the burst count. Writing a nonzero count while in BURST_RUN restarts the burst with the new count.

Top module: `tod_counter`

## Requirements
- R1: On each clock edge with no load, the time {ns, frac} advances by the step register. The step register is at address 0, with bits 31:16 in nanoseconds and bits 15:0 in 1/65536 ns.
- R2: When the advanced nanoseconds value reaches or exceeds 1,000,000,000, that amount is subtracted, the fraction is kept, and the 48-bit seconds value increments. The carry passes from the low 32 seconds bits into the high 16 bits.
- R3: A write of a nonzero value N to the burst count (address 2) makes the N edges that follow the write edge add the alternate step (address 1, same format as the step) in place of the normal step. Later edges use the normal step again.
- R4: A write of zero to the burst count ends a running burst. Edges after that write edge use the normal step.
- R5: With a trim rate R (address 4) nonzero, the trim value (address 3, in 1/65536 ns) is added to the time on the edges R, 2R, 3R, and so on, counted after the edge that wrote the rate.
- R6: A trim rate of zero adds no trim.
- R7: When a burst edge and a trim edge fall on the same cycle, both the alternate step and the trim value are added.
- R8: Writes to seconds-high (address 7) and seconds-low (address 6) only stage values and leave the live time unchanged. A nanoseconds write (address 5) loads the staged seconds and the written nanoseconds on that edge, clears the fraction, and replaces that edge's advance. Loaded nanoseconds are below one billion.
- R9: Only bits 15:0 of a seconds-high write are kept. A seconds-high read returns zeros in bits 31:16.
- R10: A nanoseconds read returns the live nanoseconds before that edge and copies the live seconds. Later seconds-low and seconds-high reads return that copy, even if the live seconds have since moved on.
- R11: After reset the time is zero, the read data is zero, and the step register holds 8.0 ns (0x0008_0000). The alternate step, burst count, trim value and trim rate are zero.
- R12: Read data appears on the clock edge that samples the read strobe. Addresses 0 to 4 return the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| tod_sec | output | 48 | Live seconds |
| tod_ns | output | 32 | Live nanoseconds |
| tod_frac | output | 16 | Live fraction of a nanosecond |

## Verification
Two functions can act on the same edge: a burst edge that adds the alternate step, and a trim edge that adds the trim value. The bench provokes this by starting a trim with rate 2 one cycle before a four-edge burst, so trim edges land both inside and after the burst. On every edge it compares the live time with a closed-form sum: the alternate steps, then the normal steps, plus the trim added once for every completed rate interval. The same closed-form approach checks the step sweep, the burst abort, and the load that overrides an edge's advance.

// File: rtl/tod_pkg.sv
package tod_pkg;

    typedef enum logic [2:0] {
        A_STEP     = 3'd0,
        A_ALT_STEP = 3'd1,
        A_BURST    = 3'd2,
        A_TRIM     = 3'd3,
        A_RATE     = 3'd4,
        A_NS       = 3'd5,
        A_SEC_LO   = 3'd6,
        A_SEC_HI   = 3'd7
    } tod_addr_e;

    typedef enum logic {
        BURST_IDLE = 1'b0,
        BURST_RUN  = 1'b1
    } burst_state_e;

endpackage

// File: rtl/tod_regs.sv
module tod_regs
    import tod_pkg::*;
#(
    parameter int REG_W = 32,
    parameter int SEC_W = 48,
    parameter int NS_W = 32,
    parameter logic [31:0] RESET_STEP = 32'h0008_0000,
    localparam int ADDR_W = 3,
    localparam int HI_W = SEC_W - REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [NS_W-1:0]   live_ns,
    input  logic [SEC_W-1:0]  live_sec,
    output logic [REG_W-1:0]  step_o,
    output logic [REG_W-1:0]  alt_step_o,
    output logic [REG_W-1:0]  burst_len_o,
    output logic [REG_W-1:0]  trim_o,
    output logic [REG_W-1:0]  rate_o,
    output logic              burst_wr_o,
    output logic              rate_wr_o,
    output logic              load_o,
    output logic [NS_W-1:0]   load_ns_o,
    output logic [SEC_W-1:0]  load_sec_o,
    output logic [REG_W-1:0]  rdata_o
);

    tod_addr_e         sel;
    logic [HI_W-1:0]   stage_hi;
    logic [REG_W-1:0]  stage_lo;
    logic [SEC_W-1:0]  snap_sec;

    always_comb begin
        sel        = tod_addr_e'(addr);
        burst_wr_o = wr && (sel == A_BURST);
        rate_wr_o  = wr && (sel == A_RATE);
        load_o     = wr && (sel == A_NS);
        load_ns_o  = NS_W'(wdata);
        load_sec_o = {stage_hi, stage_lo};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_o      <= RESET_STEP;
            alt_step_o  <= '0;
            burst_len_o <= '0;
            trim_o      <= '0;
            rate_o      <= '0;
            stage_hi    <= '0;
            stage_lo    <= '0;
        end else if (wr) begin
            unique case (sel)
                A_STEP:     step_o      <= wdata;
                A_ALT_STEP: alt_step_o  <= wdata;
                A_BURST:    burst_len_o <= wdata;
                A_TRIM:     trim_o      <= wdata;
                A_RATE:     rate_o      <= wdata;
                A_SEC_LO:   stage_lo    <= wdata;
                A_SEC_HI:   stage_hi    <= wdata[HI_W-1:0];
                A_NS:       ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o  <= '0;
            snap_sec <= '0;
        end else if (rd) begin
            unique case (sel)
                A_STEP:     rdata_o <= step_o;
                A_ALT_STEP: rdata_o <= alt_step_o;
                A_BURST:    rdata_o <= burst_len_o;
                A_TRIM:     rdata_o <= trim_o;
                A_RATE:     rdata_o <= rate_o;
                A_NS: begin
                    rdata_o  <= REG_W'(live_ns);
                    snap_sec <= live_sec;
                end
                A_SEC_LO:   rdata_o <= snap_sec[REG_W-1:0];
                A_SEC_HI:   rdata_o <= REG_W'(snap_sec[SEC_W-1:REG_W]);
            endcase
        end
    end

endmodule

// File: rtl/tod_burst_fsm.sv
module tod_burst_fsm
    import tod_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_wr,
    input  logic [CNT_W-1:0] len_wdata,
    output logic             use_alt,
    output logic [CNT_W-1:0] remaining
);

    burst_state_e     state_q, state_d;
    logic [CNT_W-1:0] rem_q, rem_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BURST_IDLE;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
        end
    end

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        unique case (state_q)
            BURST_IDLE: begin
                if (len_wr && (len_wdata != '0)) begin
                    state_d = BURST_RUN;
                    rem_d   = len_wdata;
                end
            end
            BURST_RUN: begin
                if (len_wr) begin
                    if (len_wdata != '0) begin
                        rem_d = len_wdata;
                    end else begin
                        state_d = BURST_IDLE;
                        rem_d   = '0;
                    end
                end else if (rem_q == CNT_W'(1)) begin
                    state_d = BURST_IDLE;
                    rem_d   = '0;
                end else begin
                    rem_d = rem_q - CNT_W'(1);
                end
            end
        endcase
    end

    always_comb begin
        use_alt   = (state_q == BURST_RUN);
        remaining = rem_q;
    end

endmodule

// File: rtl/tod_trim.sv
module tod_trim #(
    parameter int RATE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    input  logic              rate_wr,
    output logic              fire
);

    logic [RATE_W-1:0] cnt_q;

    always_comb begin
        fire = (rate != '0) && (cnt_q == rate - RATE_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (rate_wr || fire) begin
            cnt_q <= '0;
        end else if (rate != '0) begin
            cnt_q <= cnt_q + RATE_W'(1);
        end
    end

endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
    parameter int REG_W = 32,
    parameter int SEC_W = 48,
    parameter int NS_W = 32,
    parameter int FRAC_W = 16,
    parameter int unsigned NS_PER_SEC = 1_000_000_000,
    localparam int ACC_W = NS_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  step,
    input  logic [REG_W-1:0]  alt_step,
    input  logic              use_alt,
    input  logic [REG_W-1:0]  trim,
    input  logic              trim_fire,
    input  logic              load,
    input  logic [NS_W-1:0]   load_ns,
    input  logic [SEC_W-1:0]  load_sec,
    output logic [SEC_W-1:0]  sec_q,
    output logic [NS_W-1:0]   ns_q,
    output logic [FRAC_W-1:0] frac_q
);

    localparam logic [ACC_W-1:0] LIMIT = ACC_W'(NS_PER_SEC) << FRAC_W;

    logic [ACC_W-1:0] inc, sum, nxt;
    logic             roll;

    always_comb begin
        inc  = ACC_W'(use_alt ? alt_step : step)
             + ACC_W'(trim_fire ? trim : '0);
        sum  = {ns_q, frac_q} + inc;
        roll = (sum >= LIMIT);
        nxt  = roll ? (sum - LIMIT) : sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q  <= '0;
            ns_q   <= '0;
            frac_q <= '0;
        end else if (load) begin
            sec_q  <= load_sec;
            ns_q   <= load_ns;
            frac_q <= '0;
        end else begin
            sec_q  <= sec_q + SEC_W'(roll);
            ns_q   <= nxt[ACC_W-1:FRAC_W];
            frac_q <= nxt[FRAC_W-1:0];
        end
    end

endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
    parameter int SEC_W = 48,
    parameter int FRAC_W = 16,
    parameter int unsigned NS_PER_SEC = 1_000_000_000,
    parameter logic [31:0] RESET_STEP = 32'h0008_0000,
    localparam int REG_W = 32,
    localparam int NS_W = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [SEC_W-1:0]  tod_sec,
    output logic [NS_W-1:0]   tod_ns,
    output logic [FRAC_W-1:0] tod_frac
);

    logic [REG_W-1:0] step, alt_step, burst_len, trim, trim_rate, burst_rem;
    logic             burst_wr, rate_wr, load_stb, in_burst, trim_fire;
    logic [NS_W-1:0]  load_ns;
    logic [SEC_W-1:0] load_sec;

    tod_regs #(
        .REG_W(REG_W), .SEC_W(SEC_W), .NS_W(NS_W), .RESET_STEP(RESET_STEP)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd),
        .addr(reg_addr), .wdata(reg_wdata),
        .live_ns(tod_ns), .live_sec(tod_sec),
        .step_o(step), .alt_step_o(alt_step), .burst_len_o(burst_len),
        .trim_o(trim), .rate_o(trim_rate),
        .burst_wr_o(burst_wr), .rate_wr_o(rate_wr),
        .load_o(load_stb), .load_ns_o(load_ns), .load_sec_o(load_sec),
        .rdata_o(reg_rdata)
    );

    tod_burst_fsm #(.CNT_W(REG_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .len_wr(burst_wr), .len_wdata(reg_wdata),
        .use_alt(in_burst), .remaining(burst_rem)
    );

    tod_trim #(.RATE_W(REG_W)) u_trim (
        .clk(clk), .rst_n(rst_n), .rate(trim_rate), .rate_wr(rate_wr),
        .fire(trim_fire)
    );

    tod_accum #(
        .REG_W(REG_W), .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W),
        .NS_PER_SEC(NS_PER_SEC)
    ) u_accum (
        .clk(clk), .rst_n(rst_n), .step(step), .alt_step(alt_step),
        .use_alt(in_burst), .trim(trim), .trim_fire(trim_fire),
        .load(load_stb), .load_ns(load_ns), .load_sec(load_sec),
        .sec_q(tod_sec), .ns_q(tod_ns), .frac_q(tod_frac)
    );

    logic unused_len;
    assign unused_len = ^burst_len;

endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk
    import tod_pkg::*;
#(
    parameter int SEC_W = 48,
    parameter int NS_W = 32,
    parameter int FRAC_W = 16,
    parameter int REG_W = 32,
    parameter int unsigned NS_PER_SEC = 1_000_000_000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [2:0]        reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic [SEC_W-1:0]  tod_sec,
    input logic [NS_W-1:0]   tod_ns,
    input logic [FRAC_W-1:0] tod_frac,
    input logic              in_burst,
    input logic [REG_W-1:0]  burst_rem,
    input logic [REG_W-1:0]  trim_rate,
    input logic              trim_fire,
    input logic              load_stb
);

    logic past_ok, bad_load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok  <= 1'b0;
            bad_load <= 1'b0;
        end else begin
            past_ok <= 1'b1;
            if (reg_wr && reg_addr == A_NS)
                bad_load <= (reg_wdata >= NS_PER_SEC);
        end
    end

    // R2
    ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_load |-> (tod_ns < NS_PER_SEC));

    // R2
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(load_stb)) |-> ((tod_sec - $past(tod_sec)) <= SEC_W'(1)));

    // R8
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_NS) |=> (tod_ns == $past(reg_wdata) && tod_frac == '0));

    // R3
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_burst && burst_rem == REG_W'(1) && !(reg_wr && reg_addr == A_BURST)) |=> !in_burst);

    // R4
    burst_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_BURST && reg_wdata == '0) |=> !in_burst);

    // R6
    no_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trim_rate == '0) |-> !trim_fire);

endmodule

bind tod_counter tod_counter_chk #(
    .SEC_W(SEC_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .REG_W(REG_W),
    .NS_PER_SEC(NS_PER_SEC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tod_sec(tod_sec), .tod_ns(tod_ns),
    .tod_frac(tod_frac), .in_burst(in_burst), .burst_rem(burst_rem),
    .trim_rate(trim_rate), .trim_fire(trim_fire), .load_stb(load_stb)
);

// File: tb/tod_counter_tb.sv
`timescale 1ns/1ps
module tod_counter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [47:0] tod_sec;
    logic [31:0] tod_ns;
    logic [15:0] tod_frac;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tod_counter u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tod_sec(tod_sec), .tod_ns(tod_ns), .tod_frac(tod_frac)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_time(input string req, input logic [63:0] exp_units);
        chk(req, {16'h0, tod_ns, tod_frac}, exp_units);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic load(input logic [47:0] s, input logic [31:0] ns);
        wr(3'd7, {16'h0, s[47:32]});
        wr(3'd6, s[31:0]);
        wr(3'd5, ns);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [47:0] s0;
        logic [63:0] e;
        logic [31:0] steps [5];
        int rates [5];
        steps = '{32'h0001_0000, 32'h0003_8000, 32'h0000_0001, 32'h0123_4567, 32'h0008_0000};
        rates = '{0, 1, 2, 3, 5};

        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 sec", 64'(tod_sec), 64'h0);
        chk_time("R11 time", 64'h0);
        chk("R11 rdata", 64'(reg_rdata), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd0, v); chk("R11 step reset", 64'(v), 64'h0008_0000);
        rd(3'd4, v); chk("R11 rate reset", 64'(v), 64'h0);
        rd(3'd2, v); chk("R11 burst reset", 64'(v), 64'h0);

        // R1 step sweep
        foreach (steps[i]) begin
            wr(3'd0, steps[i]);
            rd(3'd0, v); chk("R12 step readback", 64'(v), 64'(steps[i]));
            load(48'h0, 32'd0);
            for (int n = 0; n <= 20; n++) begin
                chk_time("R1 advance", 64'(steps[i]) * 64'(n));
                @(negedge clk);
            end
        end

        // R8 staging, R9 high-word mask, R2 carry into high seconds
        wr(3'd0, 32'h0001_0000);
        s0 = tod_sec;
        wr(3'd7, 32'hABCD_1234);
        wr(3'd6, 32'hFFFF_FFFF);
        chk("R8 staged writes leave time", 64'(tod_sec), 64'(s0));
        wr(3'd5, 32'd999_999_999);
        chk("R8 load sec", 64'(tod_sec), 64'h1234_FFFF_FFFF);
        chk_time("R8 load ns frac cleared", 64'd999_999_999 << 16);
        @(negedge clk);
        chk("R2 carry to high word", 64'(tod_sec), 64'h1235_0000_0000);
        chk_time("R2 ns wrap", 64'h0);
        rd(3'd5, v);
        rd(3'd7, v); chk("R9 sec_hi read", 64'(v), 64'h0000_1235);

        // R2 rollover keeps fraction
        wr(3'd0, 32'h0003_8000);
        load(48'd5, 32'd999_999_998);
        @(negedge clk);
        chk("R2 sec after wrap", 64'(tod_sec), 64'd6);
        chk_time("R2 frac kept", (64'd1 << 16) | 64'h8000);

        // R10 snapshot consistency
        wr(3'd0, 32'h0008_0000);
        load({16'd7, 32'd1}, 32'd999_999_990);
        rd(3'd5, v); chk("R10 ns read", 64'(v), 64'd999_999_990);
        rd(3'd6, v); chk("R10 sec_lo from copy", 64'(v), 64'd1);
        rd(3'd7, v); chk("R10 sec_hi from copy", 64'(v), 64'd7);
        rd(3'd5, v); chk("R10 ns read 2", 64'(v), 64'd14);
        rd(3'd6, v); chk("R10 sec_lo new copy", 64'(v), 64'd2);

        // R3 burst
        load(48'd0, 32'd0);
        wr(3'd1, 32'h0002_0000);
        wr(3'd2, 32'd5);
        for (int k = 0; k <= 10; k++) begin
            e = (64'd16 << 16) + 64'h2_0000 * 64'((k < 5) ? k : 5)
              + 64'h8_0000 * 64'((k > 5) ? k - 5 : 0);
            chk_time("R3 burst", e);
            @(negedge clk);
        end
        rd(3'd2, v); chk("R12 burst readback", 64'(v), 64'd5);
        rd(3'd1, v); chk("R12 alt readback", 64'(v), 64'h0002_0000);

        // R4 abort
        load(48'd0, 32'd0);
        wr(3'd2, 32'd10);
        @(negedge clk);
        @(negedge clk);
        wr(3'd2, 32'd0);
        for (int k = 0; k <= 5; k++) begin
            chk_time("R4 abort", (64'd14 + 64'd8 * 64'(k)) << 16);
            @(negedge clk);
        end

        // R5/R6 trim sweep
        wr(3'd3, 32'h0000_4000);
        foreach (rates[j]) begin
            wr(3'd4, 32'd0);
            load(48'd0, 32'd0);
            wr(3'd4, 32'(rates[j]));
            for (int k = 0; k <= 12; k++) begin
                e = (64'd8 << 16) * 64'(k + 1);
                if (rates[j] != 0) e += 64'h4000 * 64'(k / rates[j]);
                chk_time(rates[j] == 0 ? "R6 trim off" : "R5 trim", e);
                @(negedge clk);
            end
        end
        rd(3'd3, v); chk("R12 trim readback", 64'(v), 64'h4000);

        // R7 burst and trim on the same edge
        wr(3'd4, 32'd0);
        load(48'd0, 32'd0);
        wr(3'd4, 32'd2);
        wr(3'd2, 32'd4);
        for (int k = 0; k <= 9; k++) begin
            e = (64'd16 << 16) + 64'h2_0000 * 64'((k < 4) ? k : 4)
              + 64'h8_0000 * 64'((k > 4) ? k - 4 : 0)
              + 64'h4000 * 64'((k + 1) / 2);
            chk_time("R7 overlap", e);
            @(negedge clk);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule